// File: doc/BRIEF.md
# Hybrid Karatsuba Binary-Field Multiplier

This block multiplies two elements of GF(2^m), held as m-bit polynomials over GF(2), and returns their product reduced modulo a fixed irreducible polynomial. The operands are split recursively into a low half and a high half, Karatsuba style. When the width is odd, the high half takes the extra bit. Each level of the recursion computes three sub-products. Once an operand is no wider than a tuned threshold, the recursion stops and a schoolbook carry-less multiplier takes over. The partial products are recombined with XOR trees into a 2m-1 bit product. That product is then folded back to m bits using the reduction polynomial, which may be a trinomial or a pentanomial.

The core is purely combinational. A parameter adds an output register, which turns it into a one-cycle pipeline stage with a valid flag. A typical use is as the field multiplier inside an elliptic-curve point arithmetic unit. All of the following are parameters: the field width, the threshold width, the polynomial form and its middle exponents, and the output register. Illegal combinations are rejected at elaboration.

Top module: `hk_gf_mul`

## Requirements
- R1: With a trinomial x^M + x^K1 + 1, `p` equals the carry-less product of `a` and `b` reduced modulo that polynomial, for any operands.
- R2: With a pentanomial x^M + x^K1 + x^K2 + x^K3 + 1 (PENTA=1, M > K1 > K2 > K3 > 0), `p` equals the product reduced modulo that pentanomial.
- R3: If either operand is zero, the result is zero.
- R4: If one operand is the polynomial 1 (only bit 0 set), the result equals the other operand.
- R5: Swapping `a` and `b` gives the same result.
- R6: With OUT_REG=1, a result accepted with `in_valid` high appears on `p` one clock later, with `out_valid` high. Cycles where `in_valid` is low raise no `out_valid`, and `p` holds the last result. With OUT_REG=0, `p` follows the operands in the same cycle and `out_valid` equals `in_valid`.
- R7: While `rst_n` is low, the registered outputs `out_valid` and `p` read zero, whatever the inputs are.
- R8: All-ones operands, and operands with only the top bit set, reduce correctly. These cases exercise every fold of the reduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on `a` and `b` are to be multiplied |
| a | input | M | First field element |
| b | input | M | Second field element |
| out_valid | output | 1 | `p` carries a new result |
| p | output | M | Reduced product |

## Verification
The bench aims at the operands that stress reduction: all ones, a single top bit, and values that fill the unreduced product up to degree 2m-2. A wrong fold exponent, or folding in the wrong order, leaves stray high-degree terms and corrupts those results while small operands still look fine. Zero and unit operands catch a middle Karatsuba term that is shifted by the wrong half width or misses a correction XOR, because such a design returns junk instead of zero or an echo of the other operand. A second instance uses a pentanomial with an odd width and a tiny threshold, which forces several uneven split levels. Idle cycles between valid ones check that the register holds its value and does not raise a spurious valid.

// File: rtl/hk_pkg.sv
package hk_pkg;

   // width of the low half when a w-bit operand is split
   function automatic int low_half(input int w);
      return w / 2;
   endfunction

   // width of the high half (takes the extra bit on odd widths)
   function automatic int high_half(input int w);
      return w - (w / 2);
   endfunction

   // width of an unreduced carry-less product of two w-bit operands
   function automatic int prod_width(input int w);
      return 2 * w - 1;
   endfunction

endpackage

// File: rtl/hk_school.sv
module hk_school #(
   parameter int W = 8
) (
   input  logic [W-1:0]               a,
   input  logic [W-1:0]               b,
   output logic [hk_pkg::prod_width(W)-1:0] p
);
   localparam int PW = hk_pkg::prod_width(W);

   if (W < 1) begin : g_bad_w
      $error("hk_school: W must be at least 1");
   end

   always_comb begin
      p = '0;
      for (int i = 0; i < W; i++) begin
         for (int j = 0; j < W; j++) begin
            p[i+j] = p[i+j] ^ (a[i] & b[j]);
         end
      end
   end

endmodule

// File: rtl/hk_kmul.sv
module hk_kmul #(
   parameter int W   = 16,
   parameter int THR = 11
) (
   input  logic [W-1:0]                     a,
   input  logic [W-1:0]                     b,
   output logic [hk_pkg::prod_width(W)-1:0] p
);
   localparam int PPW = hk_pkg::prod_width(W);

   if (THR < 1) begin : g_bad_thr
      $error("hk_kmul: THR must be at least 1");
   end

   if (W <= THR) begin : g_leaf
      hk_school #(.W(W)) u_school (
         .a (a),
         .b (b),
         .p (p)
      );
   end else begin : g_split
      localparam int LO  = hk_pkg::low_half(W);
      localparam int HI  = hk_pkg::high_half(W);
      localparam int LPW = hk_pkg::prod_width(LO);
      localparam int HPW = hk_pkg::prod_width(HI);

      logic [LPW-1:0] prod_lo;
      logic [HPW-1:0] prod_hi;
      logic [HPW-1:0] prod_sum;
      logic [HPW-1:0] middle;
      logic [HI-1:0]  a_lo_x;
      logic [HI-1:0]  b_lo_x;
      logic [HI-1:0]  a_sum;
      logic [HI-1:0]  b_sum;

      assign a_lo_x = HI'(a[LO-1:0]);
      assign b_lo_x = HI'(b[LO-1:0]);
      assign a_sum  = a_lo_x ^ a[W-1:LO];
      assign b_sum  = b_lo_x ^ b[W-1:LO];

      hk_kmul #(.W(LO), .THR(THR)) u_lo (
         .a (a[LO-1:0]),
         .b (b[LO-1:0]),
         .p (prod_lo)
      );

      hk_kmul #(.W(HI), .THR(THR)) u_hi (
         .a (a[W-1:LO]),
         .b (b[W-1:LO]),
         .p (prod_hi)
      );

      hk_kmul #(.W(HI), .THR(THR)) u_sum (
         .a (a_sum),
         .b (b_sum),
         .p (prod_sum)
      );

      // cross term: (aL+aH)(bL+bH) minus the two outer products
      assign middle = prod_sum ^ prod_hi ^ HPW'(prod_lo);

      assign p = PPW'(prod_lo)
               ^ (PPW'(prod_hi) << (2 * LO))
               ^ (PPW'(middle)  << LO);
   end

endmodule

// File: rtl/hk_fold.sv
module hk_fold #(
   parameter int M     = 31,
   parameter int K1    = 3,
   parameter int K2    = 2,
   parameter int K3    = 1,
   parameter bit PENTA = 1'b0
) (
   input  logic [hk_pkg::prod_width(M)-1:0] c,
   output logic [M-1:0]                     r
);
   localparam int CW = hk_pkg::prod_width(M);

   if (M < 2) begin : g_bad_m
      $error("hk_fold: M must be at least 2");
   end
   if (K1 < 1 || K1 >= M) begin : g_bad_k1
      $error("hk_fold: K1 must lie strictly between 0 and M");
   end

   if (PENTA) begin : g_penta
      if (!(K1 > K2 && K2 > K3 && K3 > 0)) begin : g_bad_order
         $error("hk_fold: pentanomial needs M > K1 > K2 > K3 > 0");
      end
      always_comb begin
         logic [CW-1:0] t;
         t = c;
         // top-down so that bits folded onto lower high bits are folded again
         for (int i = CW - 1; i >= M; i--) begin
            if (t[i]) begin
               t[i-M]    = ~t[i-M];
               t[i-M+K3] = ~t[i-M+K3];
               t[i-M+K2] = ~t[i-M+K2];
               t[i-M+K1] = ~t[i-M+K1];
            end
         end
         r = t[M-1:0];
      end
   end else begin : g_tri
      always_comb begin
         logic [CW-1:0] t;
         t = c;
         for (int i = CW - 1; i >= M; i--) begin
            if (t[i]) begin
               t[i-M]    = ~t[i-M];
               t[i-M+K1] = ~t[i-M+K1];
            end
         end
         r = t[M-1:0];
      end
   end

endmodule

// File: rtl/hk_gf_mul.sv
module hk_gf_mul #(
   parameter int M       = 31,
   parameter int THR     = 11,
   parameter bit PENTA   = 1'b0,
   parameter int K1      = 3,
   parameter int K2      = 2,
   parameter int K3      = 1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic         out_valid,
   output logic [M-1:0] p
);
   localparam int PPW = hk_pkg::prod_width(M);

   if (THR < 1) begin : g_bad_thr
      $error("hk_gf_mul: THR must be at least 1");
   end
   if (M < 2) begin : g_bad_m
      $error("hk_gf_mul: M must be at least 2");
   end

   logic [PPW-1:0] raw_prod;
   logic [M-1:0]   reduced;

   hk_kmul #(.W(M), .THR(THR)) u_mul (
      .a (a),
      .b (b),
      .p (raw_prod)
   );

   hk_fold #(.M(M), .K1(K1), .K2(K2), .K3(K3), .PENTA(PENTA)) u_fold (
      .c (raw_prod),
      .r (reduced)
   );

   // leading coefficient of the unreduced product comes from the top bits only
   assert_lead_coef_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      raw_prod[PPW-1] == (a[M-1] & b[M-1]));

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            p         <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) p <= reduced;
         end
      end

      assert_valid_lat_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> out_valid == $past(in_valid));

      assert_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && !$past(in_valid) |-> $stable(p));

      assert_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && (a == '0 || b == '0) |=> p == '0);

      assert_unit_R4 : assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && a == M'(1) |=> p == $past(b));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign p         = reduced;

      assert_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         (a == '0 || b == '0) |-> p == '0);

      assert_unit_R4 : assert property (@(posedge clk) disable iff (!rst_n)
         a == M'(1) |-> p == b);
   end

endmodule

// File: tb/sim_hk_gf_mul.sv
module sim_hk_gf_mul;

   localparam int M0 = 31;
   localparam int M1 = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [63:0]   a_in = '0;
   logic [63:0]   b_in = '0;
   logic          v0, v1;
   logic [M0-1:0] p0;
   logic [M1-1:0] p1;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   // trinomial x^31 + x^3 + 1, registered, default threshold
   hk_gf_mul #(.M(M0), .THR(11), .PENTA(1'b0), .K1(3), .OUT_REG(1'b1)) u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .a (a_in[M0-1:0]), .b (b_in[M0-1:0]),
      .out_valid (v0), .p (p0)
   );

   // pentanomial x^13 + x^4 + x^3 + x + 1, combinational, deep uneven recursion
   hk_gf_mul #(.M(M1), .THR(3), .PENTA(1'b1), .K1(4), .K2(3), .K3(1), .OUT_REG(1'b0)) u1 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .a (a_in[M1-1:0]), .b (b_in[M1-1:0]),
      .out_valid (v1), .p (p1)
   );

   localparam logic [63:0] POLY0 = (64'd1 << 31) | (64'd1 << 3) | 64'd1;
   localparam logic [63:0] POLY1 = (64'd1 << 13) | (64'd1 << 4) | (64'd1 << 3) | (64'd1 << 1) | 64'd1;

   // bit-serial shift-and-add reference
   function automatic logic [63:0] ref_mul(input logic [63:0] x, input logic [63:0] y,
                                           input int m, input logic [63:0] poly);
      logic [63:0] r;
      logic [63:0] mask;
      mask = (64'd1 << m) - 64'd1;
      x = x & mask;
      r = '0;
      for (int i = m - 1; i >= 0; i--) begin
         r = r << 1;
         if (r[m]) r = r ^ poly;
         if (y[i]) r = r ^ x;
      end
      return r & mask;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // reference state: expected outputs of u0 one cycle after drive, of u1 now
   logic        exp0_v = 1'b0;
   logic [63:0] exp0_p = '0;
   logic        exp1_v = 1'b0;
   logic [63:0] exp1_p = '0;
   string       tag0 = "R7";
   string       tag1 = "R2";

   task automatic step(input logic v, input logic [63:0] x, input logic [63:0] y,
                       input string t0, input string t1);
      @(negedge clk);
      check({tag0, " u0 valid R6"}, 64'(v0), 64'(exp0_v));
      check({tag0, " u0 result"}, 64'(p0), exp0_p);
      check({tag1, " u1 valid R6"}, 64'(v1), 64'(exp1_v));
      check({tag1, " u1 result"}, 64'(p1), exp1_p);
      in_valid = v;
      a_in     = x;
      b_in     = y;
      exp0_v   = v;
      if (v) exp0_p = ref_mul(x, y, M0, POLY0);
      exp1_v   = v;
      exp1_p   = ref_mul(x, y, M1, POLY1);
      tag0     = t0;
      tag1     = t1;
   endtask

   initial begin
      logic [63:0] ones;
      logic [63:0] r1, r2;
      ones = '1;
      // R7: registered outputs stay zero in reset even with live inputs
      repeat (2) @(negedge clk);
      check("R7 reset valid", 64'(v0), 64'd0);
      check("R7 reset result", 64'(p0), 64'd0);
      in_valid = 1'b1;
      a_in = 64'h1234_5678;
      b_in = 64'h0FED_CBA9;
      @(negedge clk);
      check("R7 reset valid with input", 64'(v0), 64'd0);
      check("R7 reset result with input", 64'(p0), 64'd0);
      in_valid = 1'b0;
      a_in = '0;
      b_in = '0;
      exp1_p = '0;
      @(negedge clk);
      rst_n = 1'b1;

      // R3 zero operands
      step(1'b1, 64'h0, 64'h5A5A_5A5A, "R3", "R3");
      step(1'b1, 64'h7FFF_FFFF, 64'h0, "R3", "R3");
      // R4 unit operand
      step(1'b1, 64'h1, 64'h6BCD_1234, "R4", "R4");
      step(1'b1, 64'h2345_6789, 64'h1, "R4", "R4");
      // R8 all ones and top-bit-only operands
      step(1'b1, ones, ones, "R8", "R8");
      step(1'b1, 64'h4000_0000, 64'h4000_0000, "R8", "R8");
      step(1'b1, 64'h1000, 64'h1000, "R8", "R8");
      step(1'b1, ones, 64'h4000_1000, "R8", "R8");
      // R6 idle cycles: no valid, held result
      step(1'b0, 64'h3333_3333, 64'h7777_7777, "R6", "R6");
      step(1'b0, 64'h1111_1111, 64'h2222_2222, "R6", "R6");
      // R5 commutativity: same result both orders
      r1 = ref_mul(64'h5EAD_BEEF, 64'h0123_4567, M0, POLY0);
      r2 = ref_mul(64'h0123_4567, 64'h5EAD_BEEF, M0, POLY0);
      check("R5 reference symmetric", r1, r2);
      step(1'b1, 64'h5EAD_BEEF, 64'h0123_4567, "R5", "R5");
      step(1'b1, 64'h0123_4567, 64'h5EAD_BEEF, "R5", "R5");
      // R1 / R2 random operands, with occasional idle cycles
      for (int k = 0; k < 400; k++) begin
         logic [63:0] x, y;
         x = {$urandom, $urandom};
         y = {$urandom, $urandom};
         step((k % 7) != 3, x, y, "R1", "R2");
      end
      step(1'b0, 64'h0, 64'h0, "R1", "R2");
      step(1'b0, 64'h0, 64'h0, "R1", "R2");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule